// File: doc/BRIEF.md
# Open-Drain Single-Wire Bus Master

This block is a bus master for a single-wire, open-drain device bus. Software reaches it through a small byte-wide register port with a 3-bit address. Writing one command bit starts one bus operation: a bus reset with presence detection, a write-zero bit slot, or a write-one slot that also reads back the line. The command bit reads as 1 while the operation runs and clears itself when the operation ends. Its clearing tells software that the status bits beside it hold fresh results.

All bus timing counts whole microseconds. One microsecond is one tick of a divider on the system clock, and software loads the divider with the clock frequency in MHz minus one. The block never drives the line high. It only asserts a drive-low enable for an external open-drain pad, and it reads the pad back through a synchronizer chain. A soft-reset register stops any operation in progress, frees the line and clears the state.

Top module: `owire_master`

## Requirements
- R1: After reset, the registers at offsets 0x00, 0x02 and 0x04 read 0x00 and `line_drive_low` is 0.
- R2: Writing offset 0x00 with bit 7 set starts a bus reset, bit 5 starts a write-zero slot, and bit 4 starts a write-one/read slot. The started bit reads 1 while the operation runs and clears itself when the operation ends.
- R3: A bus reset drives the line low for RESET_LOW_US µs and then releases it. Bit 7 clears PRESENCE_US µs after the release.
- R4: When a bus reset ends, bit 6 becomes 1 if the synchronized line was low at any tick whose listen-time count lies in [PRES_WIN_LO, PRES_WIN_HI) or equals PRES_SAMPLE_US. Otherwise it becomes 0. Bit 6 keeps its value until the next bus reset ends.
- R5: A write-zero slot drives the line low for SLOT_US µs and then releases it for RECOVERY_US µs before bit 5 clears. Afterwards bit 3 reads 0.
- R6: A write-one/read slot drives the line low for READ_LOW_US µs and lasts SLOT_US µs in total. Bit 3 takes the synchronized line level at the tick that ends microsecond SAMPLE_US (counted from 0).
- R7: Offset 0x02 holds the divider value D and reads it back. One bus microsecond lasts exactly D+1 clock cycles.
- R8: A write to offset 0x00 while an operation runs is ignored. The running operation, its length and its command bit are unchanged.
- R9: When a write to offset 0x00 sets more than one command bit, bus reset (bit 7) wins over write-zero (bit 5), and write-zero wins over write-one/read (bit 4).
- R10: Offset 0x04 bit 0 reads back as written. While it is 1, the line is released, any running operation is aborted, offsets 0x00 and 0x02 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| line_drive_low | output | 1 | Enable that pulls the open-drain line low |
| line_in | input | 1 | Level of the line as seen at the pad |

## Verification
The bench builds the block with shortened bus timings: a 20 µs reset pulse, a 30 µs listen time, a presence window of 5 to 15 µs with the sample point at 8 µs, and a 12 µs slot with its sample at 4 µs. A full reset then costs about fifty microseconds, so dozens of randomly mixed operations fit in the run. Divider values from 1 to 4 make the cycles-per-microsecond relation visible in every measured low time and busy time. The short window also lets a modelled slave place its low pulse clearly before, inside or after the presence window.

// File: rtl/owire_pkg.sv
package owire_pkg;

   // register offsets; software depends on these
   localparam logic [2:0] OFF_CTRL = 3'd0;
   localparam logic [2:0] OFF_DIV  = 3'd2;
   localparam logic [2:0] OFF_SRST = 3'd4;

   // bit positions inside the control register
   localparam int B_RESET = 7;
   localparam int B_PRES  = 6;
   localparam int B_WR0   = 5;
   localparam int B_WR1RD = 4;
   localparam int B_RDBIT = 3;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_RESET,
      OP_WR0,
      OP_WR1RD
   } owire_op_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_RST_LOW,
      SQ_RST_LISTEN,
      SQ_SLOT
   } owire_state_e;

endpackage

// File: rtl/owire_tick.sv
module owire_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [DIV_W-1:0] div_val,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   // the count starts from zero at each command so every microsecond is whole
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || !run) begin
         cnt_q <= '0;
      end else if (cnt_q == div_val) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick = run && (cnt_q == div_val);

   // R7
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (tick && div_val != '0) |=> (!tick || div_val != $past(div_val)));

endmodule

// File: rtl/owire_sync.sv
module owire_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b1;
               else        chain_q[i] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b1;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/owire_seq.sv
module owire_seq
   import owire_pkg::*;
#(
   parameter int RESET_LOW_US   = 511,
   parameter int PRESENCE_US    = 512,
   parameter int PRES_SAMPLE_US = 70,
   parameter int PRES_WIN_LO    = 60,
   parameter int PRES_WIN_HI    = 240,
   parameter int SLOT_US        = 60,
   parameter int READ_LOW_US    = 1,
   parameter int SAMPLE_US      = 15,
   parameter int RECOVERY_US    = 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  owire_op_e start_op,
   input  logic      tick,
   input  logic      line_s,
   output logic      busy_rst,
   output logic      busy_wr0,
   output logic      busy_wr1,
   output logic      drive_low,
   output logic      pres_q,
   output logic      bit_q
);

   localparam int W0_TOTAL = SLOT_US + RECOVERY_US;
   localparam int M1       = (RESET_LOW_US > PRESENCE_US) ? RESET_LOW_US : PRESENCE_US;
   localparam int US_MAX   = (M1 > W0_TOTAL) ? M1 : W0_TOTAL;
   localparam int US_W     = $clog2(US_MAX + 1);

   localparam logic [US_W-1:0] K_RLOW_END = US_W'(RESET_LOW_US - 1);
   localparam logic [US_W-1:0] K_PRES_END = US_W'(PRESENCE_US - 1);
   localparam logic [US_W-1:0] K_PSAMP    = US_W'(PRES_SAMPLE_US);
   localparam logic [US_W-1:0] K_WIN_LO   = US_W'(PRES_WIN_LO);
   localparam logic [US_W-1:0] K_WIN_HI   = US_W'(PRES_WIN_HI);
   localparam logic [US_W-1:0] K_W0_END   = US_W'(W0_TOTAL - 1);
   localparam logic [US_W-1:0] K_W1_END   = US_W'(SLOT_US - 1);
   localparam logic [US_W-1:0] K_W0_LOW   = US_W'(SLOT_US);
   localparam logic [US_W-1:0] K_W1_LOW   = US_W'(READ_LOW_US);
   localparam logic [US_W-1:0] K_SAMP     = US_W'(SAMPLE_US);

   owire_state_e     state_q;
   owire_op_e        op_q;
   logic [US_W-1:0]  us_q;
   logic             seen_q;
   logic             listen_hit;
   logic [US_W-1:0]  slot_end;
   logic [US_W-1:0]  slot_low;

   assign listen_hit = ((us_q >= K_WIN_LO) && (us_q < K_WIN_HI)) || (us_q == K_PSAMP);
   assign slot_end   = (op_q == OP_WR0) ? K_W0_END : K_W1_END;
   assign slot_low   = (op_q == OP_WR0) ? K_W0_LOW : K_W1_LOW;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         op_q    <= OP_NONE;
         us_q    <= '0;
         seen_q  <= 1'b0;
         pres_q  <= 1'b0;
         bit_q   <= 1'b0;
      end else if (clr) begin
         state_q <= SQ_IDLE;
         op_q    <= OP_NONE;
         us_q    <= '0;
         seen_q  <= 1'b0;
         pres_q  <= 1'b0;
         bit_q   <= 1'b0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (start_op != OP_NONE) begin
                  op_q    <= start_op;
                  us_q    <= '0;
                  seen_q  <= 1'b0;
                  state_q <= (start_op == OP_RESET) ? SQ_RST_LOW : SQ_SLOT;
               end
            end
            SQ_RST_LOW: begin
               if (tick) begin
                  if (us_q == K_RLOW_END) begin
                     us_q    <= '0;
                     state_q <= SQ_RST_LISTEN;
                  end else begin
                     us_q <= us_q + 1'b1;
                  end
               end
            end
            SQ_RST_LISTEN: begin
               if (tick) begin
                  if (listen_hit && !line_s) seen_q <= 1'b1;
                  if (us_q == K_PRES_END) begin
                     pres_q  <= seen_q || (listen_hit && !line_s);
                     state_q <= SQ_IDLE;
                     op_q    <= OP_NONE;
                  end else begin
                     us_q <= us_q + 1'b1;
                  end
               end
            end
            SQ_SLOT: begin
               if (tick) begin
                  if (us_q == K_SAMP) bit_q <= line_s;
                  if (us_q == slot_end) begin
                     state_q <= SQ_IDLE;
                     op_q    <= OP_NONE;
                  end else begin
                     us_q <= us_q + 1'b1;
                  end
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy_rst  = (state_q == SQ_RST_LOW) || (state_q == SQ_RST_LISTEN);
   assign busy_wr0  = (state_q == SQ_SLOT) && (op_q == OP_WR0);
   assign busy_wr1  = (state_q == SQ_SLOT) && (op_q == OP_WR1RD);
   assign drive_low = (state_q == SQ_RST_LOW) || ((state_q == SQ_SLOT) && (us_q < slot_low));

   // R2
   end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_rst || busy_wr0 || busy_wr1) |-> ($past(tick) || $past(clr)));

   // R3
   drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_low) |-> $past(state_q == SQ_IDLE));

   // R4
   pres_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pres_q) |-> ($past(state_q == SQ_RST_LISTEN && tick) || $past(clr)));

endmodule

// File: rtl/owire_master.sv
module owire_master
   import owire_pkg::*;
#(
   parameter int DIV_W          = 8,
   parameter int DIV_RESET      = 0,
   parameter int SYNC_STAGES    = 2,
   parameter int RESET_LOW_US   = 511,
   parameter int PRESENCE_US    = 512,
   parameter int PRES_SAMPLE_US = 70,
   parameter int PRES_WIN_LO    = 60,
   parameter int PRES_WIN_HI    = 240,
   parameter int SLOT_US        = 60,
   parameter int READ_LOW_US    = 1,
   parameter int SAMPLE_US      = 15,
   parameter int RECOVERY_US    = 1,
   parameter int MAX_SLOT_US    = 120
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] reg_addr,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       line_drive_low,
   input  logic       line_in
);

   generate
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
         $error("divider width must be 1 to 8 bits");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("synchronizer needs at least two stages");
      end
      if (PRES_WIN_LO >= PRES_WIN_HI || PRES_WIN_HI > PRESENCE_US ||
          PRES_SAMPLE_US >= PRESENCE_US) begin : g_bad_win
         $error("presence window must lie inside the listen time");
      end
      if (READ_LOW_US < 1 || SAMPLE_US <= READ_LOW_US || SAMPLE_US >= SLOT_US) begin : g_bad_samp
         $error("read sample must fall after the release and inside the slot");
      end
      if (RECOVERY_US < 1 || SLOT_US + RECOVERY_US > MAX_SLOT_US || RESET_LOW_US < 1) begin : g_bad_slot
         $error("slot length out of range");
      end
   endgenerate

   logic             soft_rst_q;
   logic [DIV_W-1:0] div_q;
   owire_op_e        start_op;
   logic             tick;
   logic             line_s;
   logic             busy_rst, busy_wr0, busy_wr1, busy_any;
   logic             seq_drive;
   logic             pres_q, bit_q;
   logic             ctrl_wr;

   assign ctrl_wr  = reg_wr && (reg_addr == OFF_CTRL) && !soft_rst_q;
   assign busy_any = busy_rst || busy_wr0 || busy_wr1;

   // command priority: reset, then write-zero, then write-one/read
   always_comb begin
      start_op = OP_NONE;
      if (ctrl_wr) begin
         if (reg_wdata[B_RESET])      start_op = OP_RESET;
         else if (reg_wdata[B_WR0])   start_op = OP_WR0;
         else if (reg_wdata[B_WR1RD]) start_op = OP_WR1RD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_rst_q <= 1'b0;
         div_q      <= DIV_W'(DIV_RESET);
      end else begin
         if (reg_wr && reg_addr == OFF_SRST) soft_rst_q <= reg_wdata[0];
         if (soft_rst_q) begin
            div_q <= DIV_W'(DIV_RESET);
         end else if (reg_wr && reg_addr == OFF_DIV) begin
            div_q <= reg_wdata[DIV_W-1:0];
         end
      end
   end

   owire_tick #(.DIV_W(DIV_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (soft_rst_q),
      .run     (busy_any),
      .div_val (div_q),
      .tick    (tick)
   );

   owire_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (line_in),
      .dout  (line_s)
   );

   owire_seq #(
      .RESET_LOW_US   (RESET_LOW_US),
      .PRESENCE_US    (PRESENCE_US),
      .PRES_SAMPLE_US (PRES_SAMPLE_US),
      .PRES_WIN_LO    (PRES_WIN_LO),
      .PRES_WIN_HI    (PRES_WIN_HI),
      .SLOT_US        (SLOT_US),
      .READ_LOW_US    (READ_LOW_US),
      .SAMPLE_US      (SAMPLE_US),
      .RECOVERY_US    (RECOVERY_US)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (soft_rst_q),
      .start_op  (start_op),
      .tick      (tick),
      .line_s    (line_s),
      .busy_rst  (busy_rst),
      .busy_wr0  (busy_wr0),
      .busy_wr1  (busy_wr1),
      .drive_low (seq_drive),
      .pres_q    (pres_q),
      .bit_q     (bit_q)
   );

   assign line_drive_low = seq_drive && !soft_rst_q;

   always_comb begin
      reg_rdata = 8'h00;
      if (!soft_rst_q && reg_addr == OFF_CTRL) begin
         reg_rdata[B_RESET] = busy_rst;
         reg_rdata[B_PRES]  = pres_q;
         reg_rdata[B_WR0]   = busy_wr0;
         reg_rdata[B_WR1RD] = busy_wr1;
         reg_rdata[B_RDBIT] = bit_q;
      end else if (!soft_rst_q && reg_addr == OFF_DIV) begin
         reg_rdata = 8'(div_q);
      end else if (reg_addr == OFF_SRST) begin
         reg_rdata[0] = soft_rst_q;
      end
   end

   // R10
   soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_q |=> (!busy_any && !pres_q && !bit_q));

   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_q)
      (busy_any && reg_wr && reg_addr == OFF_CTRL && !tick)
         |=> ($stable(busy_rst) && $stable(busy_wr0) && $stable(busy_wr1)));

   // R2
   one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy_rst, busy_wr0, busy_wr1}));

endmodule

// File: tb/owire_master_test.sv
`timescale 1ns/1ps
module owire_master_test;

   localparam int RLOW = 20, PRES = 30, PSAMP = 8, WLO = 5, WHI = 15;
   localparam int SLOT = 12, RDLOW = 1, SAMP = 4, RECOV = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       line_drive_low;
   logic       slave_low = 1'b0;
   logic       line_in;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   int cur_div = 0;
   bit model_pres = 1'b0;
   bit model_bit = 1'b0;

   assign line_in = !(line_drive_low || slave_low);

   always #4 clk = ~clk;

   owire_master #(
      .RESET_LOW_US(RLOW), .PRESENCE_US(PRES), .PRES_SAMPLE_US(PSAMP),
      .PRES_WIN_LO(WLO), .PRES_WIN_HI(WHI), .SLOT_US(SLOT),
      .READ_LOW_US(RDLOW), .SAMPLE_US(SAMP), .RECOVERY_US(RECOV)
   ) uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .line_drive_low(line_drive_low), .line_in(line_in)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // 0 none, 1 bus reset, 2 write-zero, 3 write-one/read
   function automatic int exp_op(input logic [7:0] cmd);
      if (cmd[7]) return 1;
      if (cmd[5]) return 2;
      if (cmd[4]) return 3;
      return 0;
   endfunction

   function automatic int exp_busy(input int op, input int d);
      case (op)
         1: return (RLOW + PRES) * (d + 1);
         2: return (SLOT + RECOV) * (d + 1);
         default: return SLOT * (d + 1);
      endcase
   endfunction

   function automatic int exp_drive(input int op, input int d);
      case (op)
         1: return RLOW * (d + 1);
         2: return SLOT * (d + 1);
         default: return RDLOW * (d + 1);
      endcase
   endfunction

   function automatic logic [7:0] busy_bit(input int op);
      case (op)
         1: return 8'h80;
         2: return 8'h20;
         default: return 8'h10;
      endcase
   endfunction

   task automatic reg_write(input logic [2:0] a, input logic [7:0] v);
      @(negedge clk);
      reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 3'd0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
      reg_addr = 3'd0;
   endtask

   task automatic set_div(input int d);
      logic [7:0] rb;
      reg_write(3'd2, 8'(d));
      cur_div = d;
      reg_read(3'd2, rb);
      chk(rb == 8'(d), "R7 divider readback", rb, d);
   endtask

   // runs one command; slave pulls low in [a,b) us after the release
   task automatic run_cmd(input logic [7:0] cmd, input int a, input int b, input int poke_at,
                          output int busy_c, output int drive_c,
                          output logic [7:0] first_c, output logic [7:0] final_c, output bit mixed);
      int rel = -1;
      int guard = 0;
      bit seen_drive = 1'b0;
      int u = cur_div + 1;
      busy_c = 0; drive_c = 0; mixed = 1'b0;
      @(negedge clk);
      reg_addr = 3'd0; reg_wdata = cmd; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      #1 first_c = reg_rdata;
      while ((reg_rdata & 8'hB0) != 8'h00 && guard < 20000) begin
         guard++;
         busy_c++;
         if ((reg_rdata & 8'hB0 & ~first_c) != 8'h00) mixed = 1'b1;
         if (line_drive_low) begin
            drive_c++;
            seen_drive = 1'b1;
         end else if (seen_drive) begin
            rel++;
         end
         slave_low = (rel >= a * u) && (rel < b * u);
         if (busy_c == poke_at) begin
            reg_wdata = 8'h10; reg_wr = 1'b1;
         end else begin
            reg_wr = 1'b0;
         end
         @(negedge clk);
         #1;
      end
      reg_wr = 1'b0;
      slave_low = 1'b0;
      final_c = reg_rdata;
   endtask

   task automatic do_op(input logic [7:0] cmd, input int cat, input int poke_at);
      int op, bc, dc, a, b;
      logic [7:0] f0, f1;
      bit mx;
      op = exp_op(cmd);
      a = 0; b = 0;
      if (op == 1) begin
         case (cat)
            1: begin a = 0; b = 2; end
            2: begin a = WLO + 1; b = WLO + 4; end
            3: begin a = WHI + 1; b = WHI + 4; end
            default: begin a = 0; b = 0; end
         endcase
      end else if (op == 3 && cat[0]) begin
         a = 0; b = SAMP + 2;
      end
      run_cmd(cmd, a, b, poke_at, bc, dc, f0, f1, mx);
      if (op == 1) model_pres = (cat == 2);
      if (op == 2) model_bit = 1'b0;
      if (op == 3) model_bit = !cat[0];
      // R9 priority, R2 command bit set while running
      chk((f0 & 8'hB0) == busy_bit(op), "R9 R2 running command bit", f0 & 8'hB0, busy_bit(op));
      chk(!mx, "R8 no other command bit during operation", mx, 0);
      chk(bc == exp_busy(op, cur_div), op == 1 ? "R3 reset length" :
          op == 2 ? "R5 write-zero length" : "R6 slot length", bc, exp_busy(op, cur_div));
      chk(dc == exp_drive(op, cur_div), op == 1 ? "R3 reset low time" :
          op == 2 ? "R5 write-zero low time" : "R6 read low time", dc, exp_drive(op, cur_div));
      chk(f1 == {1'b0, model_pres, 2'b00, model_bit, 3'b000},
          op == 1 ? "R4 presence status" : "R6 R5 read bit status",
          f1, {1'b0, model_pres, 2'b00, model_bit, 3'b000});
   endtask

   initial begin
      logic [7:0] rb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      reg_read(3'd0, rb); chk(rb == 8'h00, "R1 control after reset", rb, 0);
      reg_read(3'd2, rb); chk(rb == 8'h00, "R1 divider after reset", rb, 0);
      reg_read(3'd4, rb); chk(rb == 8'h00, "R1 soft reset after reset", rb, 0);
      chk(line_drive_low == 1'b0, "R1 line released", line_drive_low, 0);

      // directed: presence cases, priority, busy ignore
      set_div(1);
      do_op(8'h80, 2, -1);
      do_op(8'h80, 0, -1);
      do_op(8'h80, 1, -1);
      do_op(8'h80, 3, -1);
      do_op(8'hB0, 2, -1);
      do_op(8'h30, 0, -1);
      do_op(8'h10, 0, -1);
      do_op(8'h10, 1, -1);
      do_op(8'h80, 0, 10);

      // R10 soft reset while a bus reset runs
      set_div(2);
      reg_write(3'd0, 8'h80);
      repeat (30) @(negedge clk);
      reg_write(3'd4, 8'h01);
      #1 chk(line_drive_low == 1'b0, "R10 line released in soft reset", line_drive_low, 0);
      reg_read(3'd0, rb); chk(rb == 8'h00, "R10 control cleared", rb, 0);
      reg_read(3'd2, rb); chk(rb == 8'h00, "R10 divider cleared", rb, 0);
      reg_read(3'd4, rb); chk(rb == 8'h01, "R10 soft reset readback", rb, 1);
      reg_write(3'd0, 8'h80);
      reg_write(3'd2, 8'h07);
      #1 chk(line_drive_low == 1'b0, "R10 command ignored in soft reset", line_drive_low, 0);
      reg_write(3'd4, 8'h00);
      reg_read(3'd2, rb); chk(rb == 8'h00, "R10 divider write ignored", rb, 0);
      reg_read(3'd0, rb); chk(rb == 8'h00, "R10 no command after release", rb, 0);
      model_pres = 1'b0; model_bit = 1'b0;

      // random mix
      void'($urandom(32'd4711));
      for (int i = 0; i < 40; i++) begin
         logic [7:0] cmd;
         if (i % 8 == 0) set_div(1 + ($urandom % 4));
         cmd = 8'($urandom);
         if ((cmd & 8'hB0) == 8'h00) cmd[4] = 1'b1;
         do_op(cmd, int'($urandom % 4), ($urandom % 3 == 0) ? 1 + int'($urandom % 20) : -1);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule